// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state of a bank of interrupts, for example 56 IDs held as two 32-bit words. A per-interrupt configuration bit marks each ID as level-sensitive or edge-sensitive. Pending can be set or cleared by write-one register strobes, by rising edges on the sampled interrupt lines, and by an activation strobe that names one interrupt ID. A normal register read returns the pending state that software sees.

For level-sensitive interrupts the block keeps a software latch apart from the line. A normal read returns the latch ORed with the sampled line. A separate save/restore port gives direct word-wide access to the raw latch and to the sampled line-level register. A hypervisor or migration agent can use it to copy the exact state out and back in. A mode input chooses whether the level register follows the external lines or keeps a restored value.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset every pending latch, every sampled level bit and every configuration bit reads 0 (0 = level-sensitive).
- R2: An edge-sensitive interrupt (config bit 1) latches pending at the clock edge where sampling is on, its line is 1 and its sampled level is still 0. The latch stays set after the line falls.
- R3: Word index w covers IDs 32w..32w+31, and bit n stands for ID 32w+n. A set-pending write with bit n at 1 sets that latch at the next clock edge. A clear-pending write with bit n at 1 clears it. An activation strobe with an ID clears that latch at the next clock edge.
- R4: Same-cycle ordering for one bit. Clear-pending beats set-pending. Activation beats set-pending. A new edge on an edge-sensitive interrupt beats both activation and clear-pending.
- R5: The line of a level-sensitive interrupt never sets its latch. Its normal read is latch OR sampled level, so clear-pending or activation leaves it pending while the level stays 1, and it stops being pending when the level falls unless the latch is set. The normal read of an edge-sensitive interrupt equals its latch.
- R6: A save/restore latch read returns the raw latch word. A save/restore latch write replaces that word at the next clock edge, ahead of every other source in that cycle. Latch bits for IDs at or above the implemented count read 0.
- R7: On the level port, bit n of word w is the sampled level of ID 32w+n, with 1 meaning asserted. IDs 0..15 and IDs at or above the implemented count read 0 and ignore writes. Lines of IDs 0..15 do not exist.
- R8: With sampling on, the level register loads the lines at each clock edge. With sampling off it holds. A level-port write loads its word at the next edge, ahead of sampling, and produces no edge in that cycle.
- R9: A configuration write loads the word (1 = edge, 0 = level) at the next clock edge and reads back on the configuration read port. Bits for IDs at or above the count read 0.
- R10: An activation ID at or above the implemented count changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_IRQ-SGI_NUM | Interrupt lines for IDs SGI_NUM..NUM_IRQ-1 |
| sample_en | input | 1 | 1: level register follows lines; 0: holds restored value |
| act_valid | input | 1 | Activation strobe |
| act_id | input | ID_W | ID being activated |
| reg_idx | input | IDX_W | Word index for register port |
| reg_wdata | input | WORD_W | Write data for set, clear and configuration writes |
| reg_set_we | input | 1 | Write-one-to-set-pending strobe |
| reg_clr_we | input | 1 | Write-one-to-clear-pending strobe |
| reg_cfg_we | input | 1 | Trigger configuration write strobe |
| reg_pend_rdata | output | WORD_W | Pending word as software sees it |
| reg_cfg_rdata | output | WORD_W | Configuration word |
| sr_idx | input | IDX_W | Word index for save/restore port |
| sr_latch_we | input | 1 | Raw latch word write strobe |
| sr_latch_wdata | input | WORD_W | Raw latch write data |
| sr_level_we | input | 1 | Level word write strobe |
| sr_level_wdata | input | WORD_W | Level write data |
| sr_latch_rdata | output | WORD_W | Raw latch word |
| sr_level_rdata | output | WORD_W | Sampled level word |

## Verification
Directed sequences drive one edge-sensitive ID and one level-sensitive ID through raise, drop, clear, set and activate. These sequences separate the ORed normal read from the raw latch, and edge latching from level following. Same-cycle collisions (set with clear, edge with activation, edge with clear, restore with clear) pin down the priority order. Word writes that cover the software-generated and unimplemented lanes show the read-as-zero lanes. After that, thousands of random cycles mix toggling lines, random activations, strobes and sampling on/off. After every cycle all four read words of both indices are compared with a bench model.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

   function automatic int unsigned words_for(int unsigned n, int unsigned w);
      return (n + w - 1) / w;
   endfunction

   function automatic int unsigned idx_bits(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ipt_level_bank.sv
`timescale 1ns/1ps
module ipt_level_bank #(
   parameter int NUM_IRQ = 56,
   parameter int SGI_NUM = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic [NUM_IRQ-1:SGI_NUM] line_i,
   input  logic [NUM_IRQ-1:SGI_NUM] wr_en_i,
   input  logic [NUM_IRQ-1:SGI_NUM] wr_bit_i,
   output logic [NUM_IRQ-1:0] level_o,
   output logic [NUM_IRQ-1:0] edge_o
);

   for (genvar s = 0; s < SGI_NUM; s++) begin : g_raz
      assign level_o[s] = 1'b0;
      assign edge_o[s]  = 1'b0;
   end

   for (genvar i = SGI_NUM; i < NUM_IRQ; i++) begin : g_lane
      logic lvl_q;

      always_ff @(posedge clk) begin
         if (!rst_n)          lvl_q <= 1'b0;
         else if (wr_en_i[i]) lvl_q <= wr_bit_i[i];
         else if (sample_en)  lvl_q <= line_i[i];
      end

      assign level_o[i] = lvl_q;
      assign edge_o[i]  = sample_en & line_i[i] & ~lvl_q & ~wr_en_i[i];

      assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!sample_en && !wr_en_i[i]) |=> $stable(level_o[i]));

      assert_level_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en_i[i] |=> (level_o[i] == $past(wr_bit_i[i])));
   end

endmodule

// File: rtl/ipt_cfg_bank.sv
`timescale 1ns/1ps
module ipt_cfg_bank #(
   parameter int NUM_IRQ = 56
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] wr_en_i,
   input  logic [NUM_IRQ-1:0] wr_bit_i,
   output logic [NUM_IRQ-1:0] cfg_o
);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
      ipt_pkg::trig_e mode_q;

      always_ff @(posedge clk) begin
         if (!rst_n)          mode_q <= ipt_pkg::TRIG_LEVEL;
         else if (wr_en_i[i]) mode_q <= ipt_pkg::trig_e'(wr_bit_i[i]);
      end

      assign cfg_o[i] = (mode_q == ipt_pkg::TRIG_EDGE);

      assert_cfg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en_i[i] |=> (cfg_o[i] == $past(wr_bit_i[i])));
   end

endmodule

// File: rtl/ipt_latch_bank.sv
`timescale 1ns/1ps
module ipt_latch_bank #(
   parameter int NUM_IRQ = 56
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] cfg_i,
   input  logic [NUM_IRQ-1:0] edge_i,
   input  logic [NUM_IRQ-1:0] sw_set_i,
   input  logic [NUM_IRQ-1:0] sw_clr_i,
   input  logic [NUM_IRQ-1:0] act_i,
   input  logic [NUM_IRQ-1:0] rst_wr_en_i,
   input  logic [NUM_IRQ-1:0] rst_wr_bit_i,
   output logic [NUM_IRQ-1:0] latch_o
);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
      logic pend_q;
      logic pend_d;
      logic edge_take;

      assign edge_take = edge_i[i] & cfg_i[i];

      always_comb begin
         if (rst_wr_en_i[i]) pend_d = rst_wr_bit_i[i];
         else pend_d = ((pend_q | sw_set_i[i]) & ~sw_clr_i[i] & ~act_i[i]) | edge_take;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= pend_d;
      end

      assign latch_o[i] = pend_q;

      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_i[i] && cfg_i[i] && !rst_wr_en_i[i]) |=> latch_o[i]);

      assert_edge_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_o[i] && cfg_i[i] && !sw_clr_i[i] && !act_i[i] && !rst_wr_en_i[i])
         |=> latch_o[i]);

      assert_clr_beats_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_set_i[i] && sw_clr_i[i] && !edge_i[i] && !rst_wr_en_i[i]) |=> !latch_o[i]);

      assert_line_never_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!latch_o[i] && !cfg_i[i] && !sw_set_i[i] && !rst_wr_en_i[i]) |=> !latch_o[i]);

      assert_restore_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rst_wr_en_i[i] |=> (latch_o[i] == $past(rst_wr_bit_i[i])));
   end

endmodule

// File: rtl/ipt_word_sel.sv
`timescale 1ns/1ps
module ipt_word_sel #(
   parameter int NUM_IRQ   = 56,
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 2,
   parameter int IDX_W     = 1
) (
   input  logic [NUM_IRQ-1:0] vec_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [WORD_W-1:0]  word_o
);

   localparam int PAD_W = NUM_WORDS * WORD_W;

   logic [PAD_W-1:0] pad;

   if (PAD_W > NUM_IRQ) begin : g_pad
      assign pad = {{(PAD_W - NUM_IRQ){1'b0}}, vec_i};
   end else begin : g_nopad
      assign pad = vec_i;
   end

   always_comb begin
      word_o = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (idx_i == IDX_W'(w)) word_o = pad[w*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/irq_pend_tracker.sv
`timescale 1ns/1ps
module irq_pend_tracker #(
   parameter int NUM_IRQ = 56,
   parameter int WORD_W  = 32,
   parameter int SGI_NUM = 16,
   localparam int NUM_WORDS = ipt_pkg::words_for(NUM_IRQ, WORD_W),
   localparam int IDX_W     = ipt_pkg::idx_bits(NUM_WORDS),
   localparam int ID_W      = ipt_pkg::idx_bits(NUM_WORDS * WORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IRQ-1:SGI_NUM] irq_line,
   input  logic                     sample_en,
   input  logic                     act_valid,
   input  logic [ID_W-1:0]          act_id,
   input  logic [IDX_W-1:0]         reg_idx,
   input  logic [WORD_W-1:0]        reg_wdata,
   input  logic                     reg_set_we,
   input  logic                     reg_clr_we,
   input  logic                     reg_cfg_we,
   output logic [WORD_W-1:0]        reg_pend_rdata,
   output logic [WORD_W-1:0]        reg_cfg_rdata,
   input  logic [IDX_W-1:0]         sr_idx,
   input  logic                     sr_latch_we,
   input  logic [WORD_W-1:0]        sr_latch_wdata,
   input  logic                     sr_level_we,
   input  logic [WORD_W-1:0]        sr_level_wdata,
   output logic [WORD_W-1:0]        sr_latch_rdata,
   output logic [WORD_W-1:0]        sr_level_rdata
);

   if (SGI_NUM >= NUM_IRQ) begin : g_bad_sgi
      $error("irq_pend_tracker: SGI_NUM must be below NUM_IRQ");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("irq_pend_tracker: WORD_W must be positive");
   end

   logic [NUM_IRQ-1:0] sw_set, sw_clr, act_hit, lat_we, lat_bit, cfg_we, cfg_bit;
   logic [NUM_IRQ-1:SGI_NUM] lvl_we, lvl_bit;
   logic [NUM_IRQ-1:0] level_q, edge_hit, latch_q, cfg_q, pend_view;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
      localparam int W = i / WORD_W;
      localparam int N = i % WORD_W;
      logic reg_hit, sr_hit;
      assign reg_hit    = (reg_idx == IDX_W'(W));
      assign sr_hit     = (sr_idx == IDX_W'(W));
      assign sw_set[i]  = reg_set_we & reg_hit & reg_wdata[N];
      assign sw_clr[i]  = reg_clr_we & reg_hit & reg_wdata[N];
      assign cfg_we[i]  = reg_cfg_we & reg_hit;
      assign cfg_bit[i] = reg_wdata[N];
      assign lat_we[i]  = sr_latch_we & sr_hit;
      assign lat_bit[i] = sr_latch_wdata[N];
      assign act_hit[i] = act_valid & (act_id == ID_W'(i));
      if (i >= SGI_NUM) begin : g_lvl
         assign lvl_we[i]  = sr_level_we & sr_hit;
         assign lvl_bit[i] = sr_level_wdata[N];
      end
      assign pend_view[i] = latch_q[i] | (level_q[i] & ~cfg_q[i]);
   end

   ipt_level_bank #(.NUM_IRQ(NUM_IRQ), .SGI_NUM(SGI_NUM)) u_level (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .line_i(irq_line),
      .wr_en_i(lvl_we), .wr_bit_i(lvl_bit), .level_o(level_q), .edge_o(edge_hit)
   );

   ipt_cfg_bank #(.NUM_IRQ(NUM_IRQ)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_we), .wr_bit_i(cfg_bit), .cfg_o(cfg_q)
   );

   ipt_latch_bank #(.NUM_IRQ(NUM_IRQ)) u_latch (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_q), .edge_i(edge_hit),
      .sw_set_i(sw_set), .sw_clr_i(sw_clr), .act_i(act_hit),
      .rst_wr_en_i(lat_we), .rst_wr_bit_i(lat_bit), .latch_o(latch_q)
   );

   ipt_word_sel #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W))
      u_sel_pend (.vec_i(pend_view), .idx_i(reg_idx), .word_o(reg_pend_rdata));
   ipt_word_sel #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W))
      u_sel_cfg (.vec_i(cfg_q), .idx_i(reg_idx), .word_o(reg_cfg_rdata));
   ipt_word_sel #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W))
      u_sel_lat (.vec_i(latch_q), .idx_i(sr_idx), .word_o(sr_latch_rdata));
   ipt_word_sel #(.NUM_IRQ(NUM_IRQ), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W))
      u_sel_lvl (.vec_i(level_q), .idx_i(sr_idx), .word_o(sr_level_rdata));

   // R10: out-of-range activation touches no latch
   assert_act_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && (int'(act_id) >= NUM_IRQ)) |-> (act_hit == '0));

endmodule

// File: tb/irq_pend_tracker_bench.sv
`timescale 1ns/1ps
module irq_pend_tracker_bench;

   localparam int NI = 56;
   localparam int SG = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, sample_en, act_valid, reg_set_we, reg_clr_we, reg_cfg_we;
   logic sr_latch_we, sr_level_we;
   logic [5:0]  act_id;
   logic        reg_idx, sr_idx;
   logic [31:0] reg_wdata, sr_latch_wdata, sr_level_wdata;
   logic [31:0] reg_pend_rdata, reg_cfg_rdata, sr_latch_rdata, sr_level_rdata;
   logic [NI-1:0] line_v;
   logic [NI-1:SG] irq_line;
   assign irq_line = line_v[NI-1:SG];

   irq_pend_tracker u_irq_pend_tracker (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .sample_en(sample_en),
      .act_valid(act_valid), .act_id(act_id), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_set_we(reg_set_we), .reg_clr_we(reg_clr_we), .reg_cfg_we(reg_cfg_we),
      .reg_pend_rdata(reg_pend_rdata), .reg_cfg_rdata(reg_cfg_rdata),
      .sr_idx(sr_idx), .sr_latch_we(sr_latch_we), .sr_latch_wdata(sr_latch_wdata),
      .sr_level_we(sr_level_we), .sr_level_wdata(sr_level_wdata),
      .sr_latch_rdata(sr_latch_rdata), .sr_level_rdata(sr_level_rdata)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [NI-1:0] m_latch, m_level, m_cfg;

   task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [31:0] word_of(logic [NI-1:0] v, int w);
      logic [31:0] r = '0;
      for (int n = 0; n < 32; n++) if (w*32 + n < NI) r[n] = v[w*32 + n];
      return r;
   endfunction

   task automatic check_all(string tag);
      for (int w = 0; w < 2; w++) begin
         reg_idx = 1'(w);
         sr_idx  = 1'(w);
         #1;
         cmp(tag, "pending", reg_pend_rdata, word_of(m_latch | (m_level & ~m_cfg), w));
         cmp(tag, "config",  reg_cfg_rdata,  word_of(m_cfg, w));
         cmp(tag, "latch",   sr_latch_rdata, word_of(m_latch, w));
         cmp(tag, "level",   sr_level_rdata, word_of(m_level, w));
      end
   endtask

   task automatic clear_strobes();
      act_valid = 0; reg_set_we = 0; reg_clr_we = 0; reg_cfg_we = 0;
      sr_latch_we = 0; sr_level_we = 0;
   endtask

   task automatic tick();
      logic [NI-1:0] nl, nv, nc;
      for (int i = 0; i < NI; i++) begin
         int w = i / 32;
         int n = i % 32;
         logic lok, lwr, edg, st, cl, ac;
         lok = (i >= SG);
         lwr = sr_level_we && (sr_idx == 1'(w));
         edg = lok && sample_en && line_v[i] && !m_level[i] && !lwr;
         nv[i] = !lok ? 1'b0 : lwr ? sr_level_wdata[n] : sample_en ? line_v[i] : m_level[i];
         st = reg_set_we && (reg_idx == 1'(w)) && reg_wdata[n];
         cl = reg_clr_we && (reg_idx == 1'(w)) && reg_wdata[n];
         ac = act_valid && (int'(act_id) == i);
         if (sr_latch_we && (sr_idx == 1'(w))) nl[i] = sr_latch_wdata[n];
         else nl[i] = ((m_latch[i] | st) & ~cl & ~ac) | (edg & m_cfg[i]);
         nc[i] = (reg_cfg_we && (reg_idx == 1'(w))) ? reg_wdata[n] : m_cfg[i];
      end
      @(posedge clk);
      @(negedge clk);
      m_latch = nl; m_level = nv; m_cfg = nc;
      clear_strobes();
   endtask

   initial begin
      #(8 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      clear_strobes();
      rst_n = 0; sample_en = 1; line_v = '0; act_id = '0;
      reg_idx = 0; sr_idx = 0; reg_wdata = '0; sr_latch_wdata = '0; sr_level_wdata = '0;
      m_latch = '0; m_level = '0; m_cfg = '0;
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1;

      // configure ID20 and ID50 as edge, ID40 stays level
      reg_idx = 0; reg_wdata = 32'h0010_0000; reg_cfg_we = 1; tick();
      reg_idx = 1; reg_wdata = 32'h0004_0000; reg_cfg_we = 1; tick();
      check_all("R9");

      // edge ID20: rise latches, fall keeps it
      line_v[20] = 1; tick(); check_all("R2");
      line_v[20] = 0; tick(); tick(); check_all("R2");
      act_valid = 1; act_id = 6'd20; tick(); check_all("R3");

      // level ID40
      line_v[40] = 1; tick(); check_all("R5");
      reg_idx = 1; reg_wdata = 32'h100; reg_clr_we = 1; tick(); check_all("R5");
      line_v[40] = 0; tick(); check_all("R5");
      reg_idx = 1; reg_wdata = 32'h100; reg_set_we = 1; tick(); check_all("R3");
      act_valid = 1; act_id = 6'd40; tick(); check_all("R3");

      // collisions
      reg_idx = 1; reg_wdata = 32'h8; reg_set_we = 1; reg_clr_we = 1; tick(); check_all("R4");
      reg_idx = 1; reg_wdata = 32'h8; reg_set_we = 1; act_valid = 1; act_id = 6'd35; tick(); check_all("R4");
      line_v[50] = 1; act_valid = 1; act_id = 6'd50; tick(); check_all("R4");
      line_v[20] = 1; reg_idx = 0; reg_wdata = 32'h0010_0000; reg_clr_we = 1; tick(); check_all("R4");

      // restore latch beats clear
      sr_idx = 1; sr_latch_wdata = 32'hFFFF_FFFF; sr_latch_we = 1;
      reg_idx = 1; reg_wdata = 32'hFFFF_FFFF; reg_clr_we = 1; tick(); check_all("R6");

      // level restore with sampling off
      sample_en = 0; sr_idx = 0; sr_level_wdata = 32'hFFFF_FFFF; sr_level_we = 1; tick();
      sr_idx = 1; sr_level_wdata = 32'hA5A5_5A5A; sr_level_we = 1; tick(); check_all("R7");
      line_v = '0; tick(); check_all("R8");
      act_valid = 1; act_id = 6'd60; tick(); check_all("R10");
      sample_en = 1; tick(); check_all("R8");

      // random phase
      for (int k = 0; k < 3000; k++) begin
         for (int i = SG; i < NI; i++) if ($urandom_range(0, 7) == 0) line_v[i] = ~line_v[i];
         sample_en      = ($urandom_range(0, 7) != 0);
         act_valid      = ($urandom_range(0, 3) == 0);
         act_id         = 6'($urandom_range(0, 63));
         reg_idx        = 1'($urandom_range(0, 1));
         sr_idx         = 1'($urandom_range(0, 1));
         reg_wdata      = $urandom;
         sr_latch_wdata = $urandom;
         sr_level_wdata = $urandom;
         reg_set_we     = ($urandom_range(0, 7) == 0);
         reg_clr_we     = ($urandom_range(0, 7) == 0);
         reg_cfg_we     = ($urandom_range(0, 15) == 0);
         sr_latch_we    = ($urandom_range(0, 15) == 0);
         sr_level_we    = ($urandom_range(0, 15) == 0);
         tick();
         check_all("R3");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule